// File: doc/BRIEF.md
# Coded Reference Rate Divider

This block turns a reference clock into a one-cycle strobe at a lower rate, for use by a downstream phase comparator. A 3-bit code selects one of eight fixed ratios. A small constant table maps the code to a reload value. The set of ratios is uneven and includes 640 and 1000, so it cannot be reduced to a shift. A 12-bit down-counter then counts out the selected number of reference cycles. The reference may be a crystal-derived clock or any logic-level clock.

The code is read only when the counter reaches zero and reloads. Software or a neighbouring block may therefore change the code at any time. The period already in progress always runs to its end with the previous ratio, so the output never produces a short or merged period. The asynchronous active-low reset is released through a two-stage synchronizer. On the first clock after release, the counter is loaded from the code present at that moment.

Top module: `refdiv_top`

## Requirements
- R1: The ratio code maps to periods, in reference clock cycles, as follows: 0→8, 1→64, 2→128, 3→256, 4→640, 5→1000, 6→1024, 7→2048.
- R2: Rising edges of `ref_pulse` are exactly N reference cycles apart, where N is the ratio that was latched at the start of that period.
- R3: `ref_pulse` is high for exactly one reference clock cycle in each period.
- R4: A code change made in the middle of a period does not alter the length of that period. The new ratio applies from the next period onward.
- R5: Only the code present at the terminal count is used. Intermediate values that the code takes during a period have no effect.
- R6: While `rst_n` is low, `ref_pulse` is low. On the first clock after the internal reset release, the counter loads from the current code.
- R7: Reset release is synchronized by two clock edges. With code 0 held, the first pulse is seen after the 11th rising clock edge that follows the rise of `rst_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ratio_sel | input | 3 | Ratio code, read only at terminal count |
| ref_pulse | output | 1 | One-cycle strobe at the divided rate |

## Verification
Each of the eight codes is applied right after a strobe, and the following period is measured. This tells apart table entries that are swapped or wrong, as well as off-by-one reload values. One code change is made partway through the longest period. The bench confirms that the old period completes at full length before the new one applies, which separates read-at-reload behaviour from continuous sampling. A glitch pattern, in which the code changes twice within one period, shows that only the value present at the terminal count is used. A measurement from reset release to the first strobe pins down the synchronizer depth and the initial load.

// File: rtl/refdiv_pkg.sv
package refdiv_pkg;
  localparam int CNT_W = 12;
  localparam int SEL_W = 3;
  localparam int NUM_RATIOS = 1 << SEL_W;

  // Divide ratio selected by each code
  function automatic logic [CNT_W-1:0] ratio_of(input logic [SEL_W-1:0] code);
    logic [CNT_W-1:0] r;
    case (code)
      3'd0:    r = 12'd8;
      3'd1:    r = 12'd64;
      3'd2:    r = 12'd128;
      3'd3:    r = 12'd256;
      3'd4:    r = 12'd640;
      3'd5:    r = 12'd1000;
      3'd6:    r = 12'd1024;
      default: r = 12'd2048;
    endcase
    return r;
  endfunction

  // Counter reload value: one less than the ratio
  function automatic logic [CNT_W-1:0] reload_of(input logic [SEL_W-1:0] code);
    return ratio_of(code) - CNT_W'(1);
  endfunction
endpackage

// File: rtl/refdiv_rst_sync.sv
module refdiv_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] stage_q;
  logic [STAGES-1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= stage_d;
  end

  assign rst_sync_n = stage_q[STAGES-1];
endmodule

// File: rtl/refdiv_ratio_rom.sv
module refdiv_ratio_rom
  import refdiv_pkg::*;
(
  input  logic [SEL_W-1:0] code_i,
  output logic [CNT_W-1:0] reload_o
);
  logic [CNT_W-1:0] table_w [NUM_RATIOS];

  for (genvar g = 0; g < NUM_RATIOS; g++) begin : g_entry
    assign table_w[g] = reload_of(SEL_W'(g));
  end

  assign reload_o = table_w[code_i];
endmodule

// File: rtl/refdiv_counter.sv
module refdiv_counter #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] load_i,
  output logic [W-1:0] cnt_o,
  output logic         tc_o
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         primed_q, primed_d;
  logic         at_zero;

  assign at_zero = (cnt_q == '0);

  always_comb begin
    primed_d = 1'b1;
    cnt_d    = cnt_q;
    if (!primed_q || at_zero) cnt_d = load_i;
    else                      cnt_d = cnt_q - W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      primed_q <= 1'b0;
    end else begin
      cnt_q    <= cnt_d;
      primed_q <= primed_d;
    end
  end

  assign tc_o  = primed_q && at_zero;
  assign cnt_o = cnt_q;

  // R2: every non-terminal cycle steps down by exactly one
  assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(primed_q) && $past(cnt_q) != '0) |-> (cnt_q == $past(cnt_q) - W'(1)));

  // R6: first cycle after release takes the table value for the current code
  assert_prime_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(primed_q) |-> (cnt_q == $past(load_i)));
endmodule

// File: rtl/refdiv_top.sv
module refdiv_top
  import refdiv_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] ratio_sel,
  output logic             ref_pulse
);
  logic             rst_sync_n;
  logic [CNT_W-1:0] reload_w;
  logic [CNT_W-1:0] cnt_w;
  logic             tc_w;
  logic             pulse_q, pulse_d;

  refdiv_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  refdiv_ratio_rom u_rom (
    .code_i   (ratio_sel),
    .reload_o (reload_w)
  );

  refdiv_counter #(.W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .load_i (reload_w),
    .cnt_o  (cnt_w),
    .tc_o   (tc_w)
  );

  always_comb begin
    pulse_d = tc_w;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) pulse_q <= 1'b0;
    else             pulse_q <= pulse_d;
  end

  assign ref_pulse = pulse_q;

  // R3: strobe never lasts two cycles
  assert_single_cycle_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    pulse_q |=> !pulse_q);

  // R1: the period starting at a strobe uses the ratio of the code seen at reload
  assert_reload_ratio_R1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    pulse_q |-> (cnt_w == reload_of($past(ratio_sel))));
endmodule

// File: tb/refdiv_top_test.sv
module refdiv_top_test;
  typedef struct {
    int    len;
    string req;
  } exp_t;

  logic       clk;
  logic       rst_n;
  logic [2:0] ratio_sel;
  logic       ref_pulse;

  int   n_checks;
  int   n_fail;
  exp_t exp_q[$];

  refdiv_top uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .ratio_sel (ratio_sel),
    .ref_pulse (ref_pulse)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic int ratio_for(input int code);
    case (code)
      0: return 8;
      1: return 64;
      2: return 128;
      3: return 256;
      4: return 640;
      5: return 1000;
      6: return 1024;
      default: return 2048;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic push_exp(input int len, input string req);
    exp_t e;
    e.len = len;
    e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic wait_pulse();
    @(negedge clk);
    while (ref_pulse !== 1'b1) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  // Monitor: measure strobe spacing and width, compare against scoreboard
  int  cyc;
  int  last_cyc;
  bit  have_prev;
  bit  prev_level;
  initial begin
    cyc = 0; have_prev = 1'b0; prev_level = 1'b0; last_cyc = 0;
    forever begin
      @(negedge clk);
      cyc++;
      if (!rst_n) begin
        have_prev  = 1'b0;
        prev_level = 1'b0;
      end else begin
        if (ref_pulse === 1'b1) begin
          chk(!prev_level, "R3", 1, 0);
          if (!prev_level) begin
            if (have_prev && exp_q.size() > 0) begin
              exp_t e;
              e = exp_q.pop_front();
              chk((cyc - last_cyc) == e.len, e.req, cyc - last_cyc, e.len);
            end
            have_prev = 1'b1;
            last_cyc  = cyc;
          end
        end
        prev_level = (ref_pulse === 1'b1);
      end
    end
  end

  // Watchdog
  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  // Driver
  initial begin
    int waited;
    n_checks  = 0;
    n_fail    = 0;
    rst_n     = 1'b0;
    ratio_sel = 3'd0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk(ref_pulse === 1'b0, "R6", int'(ref_pulse), 0);
    end
    push_exp(ratio_for(0), "R2");
    rst_n = 1'b1;
    waited = 0;
    do begin
      @(negedge clk);
      waited++;
    end while (ref_pulse !== 1'b1 && waited < 100);
    chk(waited == 11, "R7", waited, 11);
    // each code applied right after a strobe sets the following period
    for (int c = 1; c < 8; c++) begin
      ratio_sel = 3'(c);
      push_exp(ratio_for(c), (c == 7) ? "R4" : "R1");
      wait_pulse();
    end
    // mid-period change during the 2048 period: that period still completes
    repeat (100) @(negedge clk);
    ratio_sel = 3'd4;
    push_exp(640, "R4");
    wait_pulse();
    // two changes within one period: only the final value counts
    repeat (50) @(negedge clk);
    ratio_sel = 3'd1;
    repeat (50) @(negedge clk);
    ratio_sel = 3'd5;
    push_exp(1000, "R5");
    while (exp_q.size() > 0) @(negedge clk);
    repeat (5) @(negedge clk);
    // reset mid-run holds the strobe low
    rst_n = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(ref_pulse === 1'b0, "R6", int'(ref_pulse), 0);
    end
    finish_run();
  end
endmodule